// File: doc/BRIEF.md
# Transmit Bit Retiming Buffer

This block sits between a host that bit-bangs serial data and a fixed-rate 1200 bit/s FSK modulator. The host hands over one bit per handshake. It drives a data line (`host_data`) and pulses a strobe (`host_strobe`). The block moves each bit onto a periodic one-cycle bit tick and tells the host it can take the next bit by pulling `ready_n` low. The bit tick comes either from a built-in divider of the system clock or from the `bit_tick_in` pin, chosen by the `USE_EXT_TICK` parameter.

The strobe has two jobs. On every bit tick its level picks the mode. A high strobe selects bypass, where the synchronized host data drives `mod_bit` directly. A low strobe selects retiming, where `mod_bit` comes from a two-stage bit pipeline. In retiming mode each rising edge of the strobe copies the data line into the first stage. Each bit tick moves the first stage into the second stage, and the second stage feeds the modulator. Both host inputs are asynchronous and pass through a two-flop synchronizer. Edge detection works on the synchronized strobe.

The controller has three named states:
- `ST_BYPASS`: mode is bypass and `ready_n` is high.
- `ST_REQUEST`: mode is retime and a bit is being requested, so `ready_n` is low while the strobe is low.
- `ST_HOLD`: mode is retime and the host has answered, so `ready_n` is high.

Transitions:
- Any state goes to `ST_BYPASS` on a tick with the strobe high.
- Any state goes to `ST_REQUEST` on a tick with the strobe low.
- `ST_REQUEST` goes to `ST_HOLD` when the synchronized strobe is high between ticks.
- Without a tick, `ST_HOLD` and `ST_BYPASS` stay where they are.

Top module: `tx_retime_top`

## Requirements
- R1: After reset `ready_n` is 1, both pipeline stages hold 1, and the block is in bypass. `mod_bit` then equals the synchronized data line, which reads 1 while the line is held high.
- R2: In bypass, `mod_bit` follows `host_data` after the two synchronizer cycles. A tick with the strobe high always returns the block to bypass.
- R3: A bit tick that samples the synchronized strobe low puts the block in retiming mode. `ready_n` is 0 from the cycle after that tick for as long as the strobe stays low.
- R4: `ready_n` is 1 whenever the synchronized strobe is 1, in every state.
- R5: A rising edge of the synchronized strobe copies the data line into the first stage. The next tick moves it to the second stage, and in retiming mode the second stage drives `mod_bit`.
- R6: In retiming mode, `mod_bit` changes only in the cycle after a bit tick.
- R7: If no strobe rising edge occurs between two ticks, the second tick repeats the previous bit on `mod_bit`.
- R8: In retiming mode, changes on `host_data` without a strobe rising edge have no effect on `mod_bit`.
- R9: With the internal divider, the tick is a single-cycle pulse that occurs once every `TICK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_in | input | 1 | External one-cycle bit tick, used when `USE_EXT_TICK`=1 |
| host_data | input | 1 | Serial data bit from host (asynchronous) |
| host_strobe | input | 1 | Load strobe and mode select from host (asynchronous) |
| ready_n | output | 1 | Active-low request for the next bit |
| mod_bit | output | 1 | Data bit to the FSK modulator |

## Verification
The assertions assume three things about the inputs:
- An external tick is a one-cycle pulse.
- The host holds its data line stable around each strobe rising edge, long enough for both signals to cross the synchronizer together.
- The strobe stays at one level for several system clocks between changes.

The stimulus keeps to this. It changes the data line several cycles before raising the strobe. It holds every strobe level for at least four cycles. It drives each tick for exactly one cycle, and never in the same cycle as a synchronized strobe edge.

// File: rtl/tx_retime_pkg.sv
package tx_retime_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS  = 2'd0,
        ST_REQUEST = 2'd1,
        ST_HOLD    = 2'd2
    } retime_state_t;

    localparam logic IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/tx_retime_sync.sv
module tx_retime_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= RST_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/tx_retime_tick.sv
module tx_retime_tick #(
    parameter int TICK_DIV     = 16,
    parameter bit USE_EXT_TICK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick,
    output logic tick
);

    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    if (USE_EXT_TICK) begin : g_ext
        assign tick = ext_tick;
    end else begin : g_div
        logic [CW-1:0] cnt_q;
        logic          tick_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                tick_q <= 1'b0;
            end else if (cnt_q == CW'(TICK_DIV - 1)) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                tick_q <= 1'b0;
            end
        end

        assign tick = tick_q;

        // R9
        tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (TICK_DIV > 1 && tick) |=> !tick);

        // R9: gap counter checked against divider period
        logic [CW:0] gap_q;
        logic        seen_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
            end else if (tick) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + 1'b1;
            end
        end

        // R9
        tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && seen_q && TICK_DIV > 1) |-> (gap_q == (CW+1)'(TICK_DIV - 1)));
    end

endmodule

// File: rtl/tx_retime_fsm.sv
module tx_retime_fsm
    import tx_retime_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic data_s,
    input  logic strobe_s,
    output logic ready_n,
    output logic mod_bit
);

    retime_state_t state_q, state_d;
    logic          strobe_d;
    logic          first_q;
    logic          second_q;
    logic          strobe_rise;

    // edge detection on synchronized strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_d <= IDLE_LEVEL;
        else        strobe_d <= strobe_s;
    end

    assign strobe_rise = strobe_s & ~strobe_d;

    // first stage: loaded by strobe rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           first_q <= IDLE_LEVEL;
        else if (strobe_rise) first_q <= data_s;
    end

    // second stage: loaded on each bit tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    second_q <= IDLE_LEVEL;
        else if (tick) second_q <= first_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (tick) begin
            state_d = strobe_s ? ST_BYPASS : ST_REQUEST;
        end else begin
            unique case (state_q)
                ST_BYPASS:  state_d = ST_BYPASS;
                ST_REQUEST: state_d = strobe_s ? ST_HOLD : ST_REQUEST;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_BYPASS;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready_n = 1'b1;
        mod_bit = data_s;
        unique case (state_q)
            ST_BYPASS: begin
                ready_n = 1'b1;
                mod_bit = data_s;
            end
            ST_REQUEST: begin
                ready_n = strobe_s;
                mod_bit = second_q;
            end
            ST_HOLD: begin
                ready_n = 1'b1;
                mod_bit = second_q;
            end
            default: begin
                ready_n = 1'b1;
                mod_bit = data_s;
            end
        endcase
    end

    // R3
    tick_low_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !strobe_s) |=> (state_q == ST_REQUEST));

    // R2
    tick_high_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && strobe_s) |=> (state_q == ST_BYPASS));

    // R4
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_s |-> ready_n);

    // R5
    second_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (second_q == $past(first_q)));

    // R6
    retime_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && state_q != ST_BYPASS) |=> $stable(mod_bit));

    // R8
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_rise |=> $stable(first_q));

endmodule

// File: rtl/tx_retime_top.sv
module tx_retime_top #(
    parameter int TICK_DIV     = 16,
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic bit_tick_in,
    input  logic host_data,
    input  logic host_strobe,
    output logic ready_n,
    output logic mod_bit
);

    logic [1:0] pins_sync;
    logic       tick;

    tx_retime_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .async_in({host_strobe, host_data}),
        .sync_out(pins_sync)
    );

    tx_retime_tick #(
        .TICK_DIV    (TICK_DIV),
        .USE_EXT_TICK(USE_EXT_TICK)
    ) u_tick (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .ext_tick(bit_tick_in),
        .tick    (tick)
    );

    tx_retime_fsm u_fsm (
        .clk     (sys_clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .data_s  (pins_sync[0]),
        .strobe_s(pins_sync[1]),
        .ready_n (ready_n),
        .mod_bit (mod_bit)
    );

endmodule

// File: tb/test_tx_retime_top.sv
module test_tx_retime_top;

    logic sys_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic bit_tick_in = 1'b0;
    logic host_data   = 1'b1;
    logic host_strobe = 1'b1;
    logic ready_n;
    logic mod_bit;
    logic div_ready_n;
    logic div_mod_bit;

    int checks = 0;
    int errors = 0;

    always #2 sys_clk = ~sys_clk;

    tx_retime_top #(.TICK_DIV(16), .USE_EXT_TICK(1'b1)) i_tx_retime_top (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .bit_tick_in(bit_tick_in),
        .host_data  (host_data),
        .host_strobe(host_strobe),
        .ready_n    (ready_n),
        .mod_bit    (mod_bit)
    );

    // internal-divider variant, strobe held low so ready_n falls on ticks
    logic div_strobe = 1'b1;
    tx_retime_top #(.TICK_DIV(12), .USE_EXT_TICK(1'b0)) i_div_variant (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .bit_tick_in(1'b0),
        .host_data  (1'b1),
        .host_strobe(div_strobe),
        .ready_n    (div_ready_n),
        .mod_bit    (div_mod_bit)
    );

    // retimed bit sequence
    localparam int NVEC = 10;
    localparam logic [NVEC-1:0] BIT_VEC = 10'b0110100011;

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic pulse_tick();
        @(negedge sys_clk);
        bit_tick_in = 1'b1;
        @(negedge sys_clk);
        bit_tick_in = 1'b0;
    endtask

    task automatic load_bit(input logic b);
        host_data = b;
        cycles(4);
        host_strobe = 1'b1;
        cycles(4);
        check(ready_n, 1'b1, "R4 ready_n high while strobe high");
        host_strobe = 1'b0;
        cycles(4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge sys_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic last;
        cycles(3);
        rst_n = 1'b1;
        cycles(3);
        // R1 reset state
        check(ready_n, 1'b1, "R1 ready_n after reset");
        check(mod_bit, 1'b1, "R1 mod_bit after reset");

        // R2 bypass follows data
        host_data = 1'b0;
        cycles(3);
        check(mod_bit, 1'b0, "R2 bypass follows data low");
        host_data = 1'b1;
        cycles(3);
        check(mod_bit, 1'b1, "R2 bypass follows data high");
        pulse_tick();
        host_data = 1'b0;
        cycles(3);
        check(mod_bit, 1'b0, "R2 tick with strobe high keeps bypass");
        host_data = 1'b1;
        cycles(3);

        // enter retiming
        host_strobe = 1'b0;
        cycles(4);
        check(ready_n, 1'b1, "R3 no request before tick");
        pulse_tick();
        check(ready_n, 1'b0, "R3 request after tick with strobe low");
        check(mod_bit, 1'b1, "R1 second stage idle level");

        // vector walk
        last = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            load_bit(BIT_VEC[i]);
            check(mod_bit, last, "R6 output unchanged before tick");
            pulse_tick();
            check(mod_bit, BIT_VEC[i], "R5 retimed bit after tick");
            check(ready_n, 1'b0, "R3 request renewed");
            last = BIT_VEC[i];
        end

        // R8 data change without strobe edge
        host_data = ~last;
        cycles(5);
        check(mod_bit, last, "R8 data change ignored");
        // R7 tick without new edge repeats bit
        pulse_tick();
        check(mod_bit, last, "R7 bit repeated");
        pulse_tick();
        check(mod_bit, last, "R7 bit repeated again");

        // exit to bypass
        host_strobe = 1'b1;
        cycles(4);
        check(ready_n, 1'b1, "R4 ready_n high on strobe high");
        pulse_tick();
        host_data = 1'b0;
        cycles(3);
        check(mod_bit, 1'b0, "R2 bypass after exit");
        host_data = 1'b1;
        cycles(3);
        check(mod_bit, 1'b1, "R2 bypass after exit high");

        // R9 internal divider: ready_n falls with period TICK_DIV
        begin
            int t0;
            int t1;
            div_strobe = 1'b0;
            t0 = 0;
            while (div_ready_n !== 1'b0 && t0 < 40) begin
                cycles(1);
                t0++;
            end
            check(div_ready_n, 1'b0, "R9 divider produced tick");
            div_strobe = 1'b1;
            cycles(4);
            div_strobe = 1'b0;
            t1 = 4;
            cycles(2);
            t1 += 2;
            while (div_ready_n !== 1'b0 && t1 < 40) begin
                cycles(1);
                t1++;
            end
            checks++;
            if (t1 != 12) begin
                errors++;
                $display("FAIL R9 tick period: actual %0d expected %0d", t1, 12);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule